// File: doc/BRIEF.md
# Descriptor Command Sequencer

This block walks a chain of 16-byte command descriptors in memory on behalf of one DMA channel. It reads a descriptor over a word-wide memory master port and decodes the operation code and the three 2-bit condition controls. For a data operation it hands address, length, direction and an end-of-stream flag to a device-side data mover and waits for that mover to finish. Afterwards it may stall on a wait condition. It then stores the channel status and the residual byte count into the descriptor's last word, may raise an interrupt, and either steps to the next descriptor or branches.

The channel's status word and its three condition-select registers stay in the surrounding register block. The sequencer reads them as inputs and answers with single-cycle pulses that the register block applies to its flags in the same clock edge. The sequencer owns only the command pointer. Software loads the pointer through a write strobe, and the strobe is ignored while the channel is running or active.

Top module: `desc_seq`

## Requirements
- R1: After reset the command pointer is zero, no memory or transfer request is raised, and every flag pulse and the interrupt are low.
- R2: A pointer write is taken with its low four bits forced to zero when status bits 15 (run) and 10 (active) are both clear. It is ignored when either bit is set.
- R3: A descriptor is fetched only when status bits 15 and 10 are both set and no transfer is pending. The fetch reads the words at pointer, pointer+4 and pointer+8. The wake clear pulse fires once as execution of the descriptor begins.
- R4: Word 0 holds the byte count in bits 15:0 and the command in bits 31:16. Command bits 15:12 give the operation, where 0 and 1 are output and 2 and 3 are input, with 1 and 3 marking the last piece. For these operations the transfer request carries word 1 as the address and the byte count as the length, and it stays high until the mover reports done.
- R5: Three cases kill the channel: a data operation whose key (command bits 10:8) is above 3, a data operation whose address word is zero, and any operation code of 8 or more. A kill pulses the dead-set, active-clear and interrupt outputs together, and it writes nothing back and starts no transfer.
- R6: Operation 7 (stop) pulses active-clear, dead-clear and flush-clear, leaves the pointer where it is, and writes nothing back.
- R7: A condition is true when (status[3:0] & sel[19:16]) equals (sel[3:0] & sel[19:16]). Each condition uses its own select register. A control code means 0 never, 1 when true, 2 when false, 3 always. Interrupt control is command bits 5:4, branch bits 3:2 and wait bits 1:0.
- R8: While the wait control holds, the descriptor is neither written back nor completed. When it stops holding, the descriptor proceeds.
- R9: Completion writes {status[15:0], residual} to pointer+12. The residual is the mover's remaining count for data operations and zero otherwise.
- R10: The interrupt pulses in the completion cycle when the interrupt control holds.
- R11: Without a branch the pointer grows by 16 and the branch-flag clear pulses. With a branch the pointer takes word 2 and the branch-flag set pulses. Operations 4 and 5 never branch.
- R12: Completing a last-type transfer (operation 1 or 3) pulses flush-clear in the same cycle as the interrupt and branch decision.
- R13: After each completion the run and active bits are tested again. If either is clear, no further descriptor is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_in | input | 16 | Channel status word (run 15, flush 13, wake 12, dead 11, active 10, device status 7:0) |
| sel_int | input | 32 | Interrupt condition select (mask 19:16, value 3:0) |
| sel_br | input | 32 | Branch condition select |
| sel_wait | input | 32 | Wait condition select |
| ptr_wr | input | 1 | Command pointer write strobe |
| ptr_wdata | input | AW | Command pointer write value |
| cmd_ptr | output | AW | Current command pointer |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, read data valid |
| mem_rdata | input | 32 | Memory read data |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_dir_in | output | 1 | Transfer direction, 1 for device-to-memory |
| xfer_last | output | 1 | Last piece of a stream |
| xfer_addr | output | AW | Transfer data address |
| xfer_len | output | 16 | Requested byte count |
| xfer_done | input | 1 | Mover completion pulse |
| xfer_resid | input | 16 | Remaining byte count at completion |
| irq | output | 1 | Interrupt pulse |
| clr_wake | output | 1 | Clear the wake flag |
| clr_active | output | 1 | Clear the active flag |
| set_dead | output | 1 | Set the dead flag |
| clr_dead | output | 1 | Clear the dead flag |
| clr_flush | output | 1 | Clear the flush flag |
| set_bt | output | 1 | Set the branch-taken flag |
| clr_bt | output | 1 | Clear the branch-taken flag |

## Verification
The bench builds the sequencer with a 16-bit address. A 256-byte memory model then holds every descriptor chain, and branch targets and sequential steps can be checked as exact byte addresses. A mover model with a programmable delay leaves room to drop the run bit in the middle of a transfer and to change device status while a descriptor stalls on its wait condition. The same device status value drives the true and false sides of branch, wait and interrupt.

// File: rtl/desc_seq.sv
module desc_seq #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   status_in,
  input  logic [31:0]   sel_int,
  input  logic [31:0]   sel_br,
  input  logic [31:0]   sel_wait,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  output logic [AW-1:0] cmd_ptr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          xfer_req,
  output logic          xfer_dir_in,
  output logic          xfer_last,
  output logic [AW-1:0] xfer_addr,
  output logic [15:0]   xfer_len,
  input  logic          xfer_done,
  input  logic [15:0]   xfer_resid,
  output logic          irq,
  output logic          clr_wake,
  output logic          clr_active,
  output logic          set_dead,
  output logic          clr_dead,
  output logic          clr_flush,
  output logic          set_bt,
  output logic          clr_bt
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_EXEC, S_XFER, S_WAIT, S_WB, S_NEXT} state_t;

  state_t      state;
  logic [1:0]  widx;
  logic [31:0] w0, w1, w2;
  logic [15:0] resid;

  function automatic logic cond_of(input logic [31:0] sel, input logic [3:0] dev);
    return (dev & sel[19:16]) == (sel[3:0] & sel[19:16]);
  endfunction

  function automatic logic ctl_hit(input logic [1:0] c, input logic t);
    case (c)
      2'd0:    return 1'b0;
      2'd1:    return t;
      2'd2:    return !t;
      default: return 1'b1;
    endcase
  endfunction

  wire [3:0] op      = w0[31:28];
  wire [2:0] key     = w0[26:24];
  wire [1:0] ic      = w0[21:20];
  wire [1:0] bc      = w0[19:18];
  wire [1:0] wc      = w0[17:16];
  wire       go      = status_in[15] & status_in[10];
  wire       locked  = status_in[15] | status_in[10];
  wire [3:0] dev     = status_in[3:0];
  wire       is_data = (op[3:2] == 2'b00);
  wire       is_ls   = (op == 4'd4) || (op == 4'd5);
  wire       in_exec = (state == S_EXEC);
  wire       in_next = (state == S_NEXT);
  wire       kill    = in_exec && (op[3] || (is_data && (key > 3'd3 || w1 == 32'd0)));
  wire       stop_c  = in_exec && (op == 4'd7);
  wire       wait_hit = ctl_hit(wc, cond_of(sel_wait, dev));
  wire       br_take  = !is_ls && ctl_hit(bc, cond_of(sel_br, dev));

  logic unused_bits;
  assign unused_bits = ^{w0[23:22], w2, status_in[14:11], status_in[9:4],
                         sel_int[31:20], sel_int[15:4], sel_br[31:20], sel_br[15:4],
                         sel_wait[31:20], sel_wait[15:4]};

  assign clr_wake   = in_exec;
  assign set_dead   = kill;
  assign clr_active = kill | stop_c;
  assign clr_dead   = stop_c;
  assign clr_flush  = stop_c | (in_next && is_data && op[0]);
  assign irq        = kill | (in_next && ctl_hit(ic, cond_of(sel_int, dev)));
  assign set_bt     = in_next && br_take;
  assign clr_bt     = in_next && !br_take;

  assign mem_req    = (state == S_FETCH) || (state == S_WB);
  assign mem_we     = (state == S_WB);
  assign mem_addr   = cmd_ptr + ((state == S_WB) ? AW'(12) : AW'({widx, 2'b00}));
  assign mem_wdata  = {status_in, resid};

  assign xfer_req    = (state == S_XFER);
  assign xfer_dir_in = op[1];
  assign xfer_last   = op[0];
  assign xfer_addr   = w1[AW-1:0];
  assign xfer_len    = w0[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      widx    <= '0;
      w0      <= '0;
      w1      <= '0;
      w2      <= '0;
      resid   <= '0;
      cmd_ptr <= '0;
    end else begin
      if (ptr_wr && !locked)
        cmd_ptr <= {ptr_wdata[AW-1:4], 4'b0000};
      case (state)
        S_IDLE:
          if (go) begin
            widx  <= '0;
            state <= S_FETCH;
          end
        S_FETCH:
          if (mem_ack) begin
            case (widx)
              2'd0:    w0 <= mem_rdata;
              2'd1:    w1 <= mem_rdata;
              default: w2 <= mem_rdata;
            endcase
            widx <= widx + 2'd1;
            if (widx == 2'd2) state <= S_EXEC;
          end
        S_EXEC:
          if (kill || stop_c) state <= S_IDLE;
          else if (is_data)   state <= S_XFER;
          else begin
            resid <= '0;
            state <= S_WAIT;
          end
        S_XFER:
          if (xfer_done) begin
            resid <= xfer_resid;
            state <= S_WAIT;
          end
        S_WAIT:
          if (!wait_hit) state <= S_WB;
          else if (!go)  state <= S_IDLE;
        S_WB:
          if (mem_ack) state <= S_NEXT;
        S_NEXT: begin
          cmd_ptr <= br_take ? w2[AW-1:0] : cmd_ptr + AW'(16);
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module desc_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   status_in,
  input logic          ptr_wr,
  input logic [AW-1:0] cmd_ptr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          xfer_req,
  input logic          xfer_done,
  input logic          irq,
  input logic          clr_active,
  input logic          set_dead,
  input logic          clr_dead,
  input logic          set_bt,
  input logic          clr_bt
);
  a_r5_kill_flags: assert property (@(posedge clk) disable iff (!rst_n)
    set_dead |-> clr_active && irq);

  a_r11_bt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_bt && clr_bt));

  a_r11_advance: assert property (@(posedge clk) disable iff (!rst_n)
    clr_bt |=> cmd_ptr == $past(cmd_ptr) + AW'(16));

  a_r2_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr && (status_in[15] || status_in[10]) && !set_bt && !clr_bt) |=> $stable(cmd_ptr));

  a_r6_stop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_dead && !ptr_wr) |=> $stable(cmd_ptr));

  a_r4_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_done) |=> xfer_req);

  a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r3_one_master: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && xfer_req));
endmodule

bind desc_seq desc_seq_chk #(.AW(AW)) u_chk (.*);

// File: tb/desc_seq_bench.sv
module desc_seq_bench;
  localparam int AW = 16;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   st = '0;
  logic [31:0]   sel_int = '0, sel_br = '0, sel_wait = '0;
  logic          ptr_wr = 1'b0;
  logic [AW-1:0] ptr_wdata = '0;
  logic [AW-1:0] cmd_ptr;
  logic          mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          xfer_req, xfer_dir_in, xfer_last, xfer_done;
  logic [AW-1:0] xfer_addr;
  logic [15:0]   xfer_len, xfer_resid;
  logic          irq, clr_wake, clr_active, set_dead, clr_dead, clr_flush, set_bt, clr_bt;

  logic [31:0] mem [0:63];
  int errs = 0, checks = 0;
  int irq_cnt = 0, wake_cnt = 0, sbt_cnt = 0, cbt_cnt = 0;
  int x_cnt = 0, mv_cnt = 0, mv_delay = 2;
  logic [AW-1:0] x_addr;
  logic [15:0] x_len;
  logic x_dir, x_last;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_seq #(.AW(AW)) u_desc_seq (
    .clk(clk), .rst_n(rst_n), .status_in(st), .sel_int(sel_int), .sel_br(sel_br),
    .sel_wait(sel_wait), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata), .cmd_ptr(cmd_ptr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .xfer_req(xfer_req), .xfer_dir_in(xfer_dir_in),
    .xfer_last(xfer_last), .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_done(xfer_done),
    .xfer_resid(xfer_resid), .irq(irq), .clr_wake(clr_wake), .clr_active(clr_active),
    .set_dead(set_dead), .clr_dead(clr_dead), .clr_flush(clr_flush), .set_bt(set_bt),
    .clr_bt(clr_bt)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:2]];
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      xfer_done <= 1'b0;
      xfer_resid <= '0;
      mv_cnt <= 0;
    end else if (xfer_req && !xfer_done) begin
      if (mv_cnt >= mv_delay) begin
        xfer_done <= 1'b1;
        xfer_resid <= xfer_len - 16'd3;
        x_cnt <= x_cnt + 1;
        x_addr <= xfer_addr; x_len <= xfer_len; x_dir <= xfer_dir_in; x_last <= xfer_last;
        mv_cnt <= 0;
      end else mv_cnt <= mv_cnt + 1;
    end else xfer_done <= 1'b0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (clr_active) st[10] <= 1'b0;
      if (set_dead)   st[11] <= 1'b1;
      if (clr_dead)   st[11] <= 1'b0;
      if (clr_flush)  st[13] <= 1'b0;
      if (clr_wake)   st[12] <= 1'b0;
      if (irq)        irq_cnt <= irq_cnt + 1;
      if (clr_wake)   wake_cnt <= wake_cnt + 1;
      if (set_bt)     sbt_cnt <= sbt_cnt + 1;
      if (clr_bt)     cbt_cnt <= cbt_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_desc(input int a, input logic [15:0] cmd, input logic [15:0] req,
                          input logic [31:0] addr, input logic [31:0] dep);
    mem[a/4]     = {cmd, req};
    mem[a/4 + 1] = addr;
    mem[a/4 + 2] = dep;
    mem[a/4 + 3] = 32'h0;
  endtask

  task automatic load_ptr(input logic [AW-1:0] v);
    @(negedge clk);
    ptr_wr = 1'b1; ptr_wdata = v;
    @(negedge clk);
    ptr_wr = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 cmd_ptr", 32'(cmd_ptr), 32'h0);
    check("R1 mem_req", 32'(mem_req), 32'h0);
    check("R1 xfer_req", 32'(xfer_req), 32'h0);
    check("R1 pulses", 32'({irq, clr_wake, clr_active, set_dead, clr_dead, clr_flush, set_bt, clr_bt}), 32'h0);
  endtask

  task automatic t_ptr_load;
    st = 16'h0000;
    load_ptr(16'h0047);
    check("R2 aligned load", 32'(cmd_ptr), 32'h40);
    st = 16'h8000;
    load_ptr(16'h0080);
    cycles(10);
    check("R2 ignored while run", 32'(cmd_ptr), 32'h40);
    check("R3 no fetch without active", 32'(wake_cnt), 32'h0);
    st = 16'h0400;
    load_ptr(16'h0090);
    check("R2 ignored while active", 32'(cmd_ptr), 32'h40);
    st = 16'h0000;
  endtask

  task automatic t_output_last;
    int irq0 = irq_cnt, w0 = wake_cnt, c0 = cbt_cnt;
    put_desc(16'h40, 16'h1030, 16'd10, 32'h100, 32'h0);
    put_desc(16'h50, 16'h7000, 16'd0, 32'h0, 32'h0);
    st = 16'hB400;
    cycles(60);
    check("R4 xfer count", 32'(x_cnt), 32'd1);
    check("R4 xfer addr", 32'(x_addr), 32'h100);
    check("R4 xfer len", 32'(x_len), 32'd10);
    check("R4 xfer dir/last", 32'({x_dir, x_last}), 32'b01);
    check("R9 writeback", mem[16'h4C/4], 32'hA4000007);
    check("R10 irq always", 32'(irq_cnt - irq0), 32'd1);
    check("R11 advance then stop", 32'(cmd_ptr), 32'h50);
    check("R11 bt clear", 32'(cbt_cnt - c0), 32'd1);
    check("R3 wake pulses", 32'(wake_cnt - w0), 32'd2);
    check("R6 R12 status after stop", 32'(st), 32'h8000);
  endtask

  task automatic t_branch;
    int s0 = sbt_cnt, irq0 = irq_cnt;
    st = 16'h0000;
    load_ptr(16'h0080);
    put_desc(16'h80, 16'h6004, 16'd0, 32'h0, 32'h00C0);
    put_desc(16'hC0, 16'h6008, 16'd0, 32'h0, 32'h0000);
    put_desc(16'hD0, 16'h7000, 16'd0, 32'h0, 32'h0);
    sel_br = 32'h000F_0005;
    st = 16'h8405;
    cycles(80);
    check("R11 R7 branch taken then advance", 32'(cmd_ptr), 32'hD0);
    check("R11 bt set once", 32'(sbt_cnt - s0), 32'd1);
    check("R9 nop writeback", mem[16'h8C/4], 32'h84050000);
    check("R9 second writeback", mem[16'hCC/4], 32'h84050000);
    check("R10 irq never", 32'(irq_cnt - irq0), 32'd0);
    sel_br = '0;
  endtask

  task automatic t_wait;
    int irq0 = irq_cnt;
    st = 16'h0000;
    load_ptr(16'h0020);
    put_desc(16'h20, 16'h6021, 16'd0, 32'h0, 32'h0);
    put_desc(16'h30, 16'h7000, 16'd0, 32'h0, 32'h0);
    mem[16'h2C/4] = 32'hDEADBEEF;
    sel_wait = 32'h000F_0003;
    sel_int  = 32'h000F_0003;
    st = 16'h8403;
    cycles(30);
    check("R8 stalled no writeback", mem[16'h2C/4], 32'hDEADBEEF);
    check("R8 stalled pointer", 32'(cmd_ptr), 32'h20);
    check("R8 no irq while stalled", 32'(irq_cnt - irq0), 32'd0);
    st = 16'h8400;
    cycles(30);
    check("R8 writeback after release", mem[16'h2C/4], 32'h84000000);
    check("R8 pointer after release", 32'(cmd_ptr), 32'h30);
    check("R10 R7 irq if-false", 32'(irq_cnt - irq0), 32'd1);
    sel_wait = '0;
    sel_int = '0;
  endtask

  task automatic t_kill;
    int irq0 = irq_cnt, x0 = x_cnt;
    st = 16'h0000;
    load_ptr(16'h0000);
    put_desc(16'h00, 16'h2400, 16'd8, 32'h100, 32'h0);
    mem[16'h0C/4] = 32'h11111111;
    st = 16'h8400;
    cycles(30);
    check("R5 key4 dead/active", 32'(st[11:10]), 32'b10);
    check("R5 key4 irq", 32'(irq_cnt - irq0), 32'd1);
    check("R5 key4 no xfer", 32'(x_cnt - x0), 32'd0);
    check("R5 key4 no writeback", mem[16'h0C/4], 32'h11111111);
    check("R5 key4 pointer", 32'(cmd_ptr), 32'h0);
    st = 16'h0000;
    load_ptr(16'h00E0);
    put_desc(16'hE0, 16'h3000, 16'd8, 32'h0, 32'h0);
    mem[16'hEC/4] = 32'h22222222;
    st = 16'h8400;
    cycles(30);
    check("R5 zero addr dead/active", 32'(st[11:10]), 32'b10);
    check("R5 zero addr irq", 32'(irq_cnt - irq0), 32'd2);
    check("R5 zero addr no writeback", mem[16'hEC/4], 32'h22222222);
  endtask

  task automatic t_recheck;
    int w0;
    st = 16'h0000;
    load_ptr(16'h0060);
    put_desc(16'h60, 16'h3000, 16'd20, 32'h100, 32'h0);
    put_desc(16'h70, 16'h6000, 16'd0, 32'h0, 32'h0);
    mv_delay = 20;
    w0 = wake_cnt;
    st = 16'hA400;
    cycles(14);
    st[15] = 1'b0;
    cycles(60);
    check("R4 input-last dir/last", 32'({x_dir, x_last}), 32'b11);
    check("R9 residual writeback", mem[16'h6C/4], 32'h24000011);
    check("R12 flush cleared", 32'(st[13]), 32'h0);
    check("R13 pointer advanced", 32'(cmd_ptr), 32'h70);
    check("R13 no further fetch", 32'(wake_cnt - w0), 32'd1);
    mv_delay = 2;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ptr_load;
    t_output_last;
    t_branch;
    t_wait;
    t_kill;
    t_recheck;
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule